// File: doc/BRIEF.md
# Same-Address Contention Busy Arbiter

This block sits beside a two-port memory and arbitrates between the two ports when both of them select the same word in the same cycle. Each clock it compares the chip enables and addresses of the left and right ports. When both enables are low and the addresses are equal, one port keeps access and the other receives an active-low busy. That busy also gates the losing port's write strobe. The read/write control never enters the decision.

The port that reached the shared location first wins. A port counts as earlier when it held the same enable and address in the previous cycle. When both ports arrive in the same cycle, a fixed priority gives the grant to the left port. A grant stays in force for as long as the match lasts. A mode input turns the block into a slave. In slave mode it arbitrates nothing, holds both busy outputs high, and uses each port's busy input only to block that port's writes.

Top module: `contention_arbiter`

## Requirements
- R1: Contention exists only while both chip enables are low and every address bit of the two ports is equal. In every other cycle, both busy outputs are high in the following cycle.
- R2: The write controls of both ports have no effect on arbitration. A contention made up of two reads produces the same busy result as one made up of two writes.
- R3: When one port already held its enable low on the same address in the previous cycle and the other port has just arrived, the newcomer's busy goes low one clock after its arrival.
- R4: Both busy outputs are never low in the same cycle.
- R5: When both ports arrive at the matching address in the same cycle, the left port wins and the right busy goes low in the next cycle.
- R6: While the match persists, the grant holds. Changes on the losing port's write control, or on the winner's write control, do not move busy to the other side.
- R7: In master mode, a port's write strobe is high exactly when its enable and its write control are both low and that port is not the loser of the arbitration decision made in that same cycle.
- R8: In slave mode (mode input high), both busy outputs are high from the next cycle on. Each port's write strobe is then blocked exactly while that port's busy input is low. In master mode, the busy inputs have no effect.
- R9: Busy is released (goes high) one clock after the addresses stop matching or either enable goes high.
- R10: During and right after reset, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = slave (busy inputs inhibit writes), 0 = master (arbitrate) |
| lft_cs_n | input | 1 | Left port chip enable, active low |
| lft_addr | input | ADDR_W (11) | Left port address |
| lft_wr_n | input | 1 | Left port write control, active low |
| lft_busy_in_n | input | 1 | Left write inhibit used in slave mode, active low |
| rgt_cs_n | input | 1 | Right port chip enable, active low |
| rgt_addr | input | ADDR_W (11) | Right port address |
| rgt_wr_n | input | 1 | Right port write control, active low |
| rgt_busy_in_n | input | 1 | Right write inhibit used in slave mode, active low |
| lft_busy_n | output | 1 | Registered busy to the left port, active low |
| rgt_busy_n | output | 1 | Registered busy to the right port, active low |
| lft_wr_en | output | 1 | Gated left write strobe to the memory, active high |
| rgt_wr_en | output | 1 | Gated right write strobe to the memory, active high |

## Verification
The write strobes are combinational, so they are due in the same cycle the inputs are applied. The busy outputs come from a register and follow one clock after the arbitration decision. The bench drives each cycle's inputs just after the falling edge and samples one nanosecond later. At that point it compares the strobes against the model's decision for the current cycle, and compares the busy outputs against the model's state from the previous rising edge. The model advances only at the next rising edge. Arrival order, ties, sticky grants, release and slave gating are each reached through these same per-cycle comparisons.

// File: rtl/carb_pkg.sv
package carb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int NPORT = 2;
    localparam int P_L   = 0;
    localparam int P_R   = 1;
endpackage

// File: rtl/carb_match.sv
module carb_match #(
    parameter int ADDR_W = 11
) (
    input  logic              a_cs_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_cs_n,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              hit
);
    // both selected and every address bit equal
    always_comb begin
        hit = !a_cs_n && !b_cs_n && (a_addr == b_addr);
    end
endmodule

// File: rtl/carb_arrival.sv
module carb_arrival #(
    parameter int ADDR_W = 11
) (
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hist_vld,
    input  logic [ADDR_W-1:0] hist_addr,
    output logic              settled
);
    // a port is "earlier" when it sat on the same word last cycle
    always_comb begin
        settled = !cs_n && hist_vld && (hist_addr == addr);
    end
endmodule

// File: rtl/carb_pick.sv
module carb_pick
    import carb_pkg::*;
(
    input  logic   slave_mode,
    input  logic   hit,
    input  owner_e owner_q,
    input  logic   l_settled,
    input  logic   r_settled,
    output owner_e owner_d
);
    always_comb begin
        owner_d = OWN_NONE;
        if (slave_mode || !hit) begin
            owner_d = OWN_NONE;
        end else if (owner_q != OWN_NONE) begin
            owner_d = owner_q;                 // sticky while match lasts
        end else if (r_settled && !l_settled) begin
            owner_d = OWN_RIGHT;
        end else begin
            owner_d = OWN_LEFT;                // left earlier, or a tie
        end
    end
endmodule

// File: rtl/carb_wgate.sv
module carb_wgate (
    input  logic cs_n,
    input  logic wr_n,
    input  logic inhibit,
    output logic wr_en
);
    always_comb begin
        wr_en = !cs_n && !wr_n && !inhibit;
    end
endmodule

// File: rtl/contention_arbiter.sv
module contention_arbiter
    import carb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              lft_cs_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_wr_n,
    input  logic              lft_busy_in_n,
    input  logic              rgt_cs_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_wr_n,
    input  logic              rgt_busy_in_n,
    output logic              lft_busy_n,
    output logic              rgt_busy_n,
    output logic              lft_wr_en,
    output logic              rgt_wr_en
);
    typedef struct packed {
        owner_e            owner;
        logic              l_hv;
        logic [ADDR_W-1:0] l_ha;
        logic              r_hv;
        logic [ADDR_W-1:0] r_ha;
        logic              l_busy_n;
        logic              r_busy_n;
    } state_t;

    state_t state_d, state_q;

    logic   hit;
    logic   l_settled, r_settled;
    owner_e owner_nx;

    logic [NPORT-1:0] p_cs_n, p_wr_n, p_inh, p_wr_en;

    carb_match #(.ADDR_W(ADDR_W)) u_match (
        .a_cs_n (lft_cs_n),
        .a_addr (lft_addr),
        .b_cs_n (rgt_cs_n),
        .b_addr (rgt_addr),
        .hit    (hit)
    );

    carb_arrival #(.ADDR_W(ADDR_W)) u_arr_l (
        .cs_n      (lft_cs_n),
        .addr      (lft_addr),
        .hist_vld  (state_q.l_hv),
        .hist_addr (state_q.l_ha),
        .settled   (l_settled)
    );

    carb_arrival #(.ADDR_W(ADDR_W)) u_arr_r (
        .cs_n      (rgt_cs_n),
        .addr      (rgt_addr),
        .hist_vld  (state_q.r_hv),
        .hist_addr (state_q.r_ha),
        .settled   (r_settled)
    );

    carb_pick u_pick (
        .slave_mode (slave_mode),
        .hit        (hit),
        .owner_q    (state_q.owner),
        .l_settled  (l_settled),
        .r_settled  (r_settled),
        .owner_d    (owner_nx)
    );

    // per-port write inhibit: own decision in master, pin in slave
    always_comb begin
        p_cs_n[P_L] = lft_cs_n;
        p_cs_n[P_R] = rgt_cs_n;
        p_wr_n[P_L] = lft_wr_n;
        p_wr_n[P_R] = rgt_wr_n;
        if (slave_mode) begin
            p_inh[P_L] = !lft_busy_in_n;
            p_inh[P_R] = !rgt_busy_in_n;
        end else begin
            p_inh[P_L] = (owner_nx == OWN_RIGHT);
            p_inh[P_R] = (owner_nx == OWN_LEFT);
        end
    end

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_wgate
        carb_wgate u_wgate (
            .cs_n    (p_cs_n[gi]),
            .wr_n    (p_wr_n[gi]),
            .inhibit (p_inh[gi]),
            .wr_en   (p_wr_en[gi])
        );
    end

    always_comb begin
        state_d          = state_q;
        state_d.owner    = owner_nx;
        state_d.l_hv     = !lft_cs_n;
        state_d.l_ha     = lft_addr;
        state_d.r_hv     = !rgt_cs_n;
        state_d.r_ha     = rgt_addr;
        state_d.l_busy_n = slave_mode || (owner_nx != OWN_RIGHT);
        state_d.r_busy_n = slave_mode || (owner_nx != OWN_LEFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.owner    <= OWN_NONE;
            state_q.l_busy_n <= 1'b1;
            state_q.r_busy_n <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign lft_busy_n = state_q.l_busy_n;
    assign rgt_busy_n = state_q.r_busy_n;
    assign lft_wr_en  = p_wr_en[P_L];
    assign rgt_wr_en  = p_wr_en[P_R];
endmodule

// File: rtl/carb_checker.sv
module carb_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              lft_cs_n,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              lft_wr_n,
    input logic              lft_busy_in_n,
    input logic              rgt_cs_n,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              rgt_wr_n,
    input logic              lft_busy_n,
    input logic              rgt_busy_n,
    input logic              lft_wr_en,
    input logic              rgt_wr_en
);
    logic same;
    assign same = !lft_cs_n && !rgt_cs_n && (lft_addr == rgt_addr);

    AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lft_busy_n && !rgt_busy_n));                                          // R4
    AST_RELEASE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !same |=> (lft_busy_n && rgt_busy_n));                                   // R9
    AST_SLAVE_BUSY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |=> (lft_busy_n && rgt_busy_n));                              // R8
    AST_SLAVE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !lft_busy_in_n) |-> !lft_wr_en);                          // R8
    AST_STICKY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rgt_busy_n && same && !slave_mode) |=> !rgt_busy_n);                   // R6
    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (lft_wr_n || lft_cs_n) |-> !lft_wr_en);                                  // R7
    AST_READ_NO_STROBE_R: assert property (@(posedge clk) disable iff (!rst_n)
        (rgt_wr_n || rgt_cs_n) |-> !rgt_wr_en);                                  // R7
endmodule

bind contention_arbiter carb_checker #(.ADDR_W(ADDR_W)) u_carb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .slave_mode    (slave_mode),
    .lft_cs_n      (lft_cs_n),
    .lft_addr      (lft_addr),
    .lft_wr_n      (lft_wr_n),
    .lft_busy_in_n (lft_busy_in_n),
    .rgt_cs_n      (rgt_cs_n),
    .rgt_addr      (rgt_addr),
    .rgt_wr_n      (rgt_wr_n),
    .lft_busy_n    (lft_busy_n),
    .rgt_busy_n    (rgt_busy_n),
    .lft_wr_en     (lft_wr_en),
    .rgt_wr_en     (rgt_wr_en)
);

// File: tb/contention_arbiter_bench.sv
`timescale 1ns/1ps
module contention_arbiter_bench;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          lft_cs_n = 1'b1, rgt_cs_n = 1'b1;
    logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
    logic          lft_wr_n = 1'b1, rgt_wr_n = 1'b1;
    logic          lft_busy_in_n = 1'b1, rgt_busy_in_n = 1'b1;
    logic          lft_busy_n, rgt_busy_n, lft_wr_en, rgt_wr_en;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_own = 0;          // 0 none, 1 left wins, 2 right wins
    bit m_lv = 0, m_rv = 0;
    int m_la = 0, m_ra = 0;

    always #2.5 clk = ~clk;

    contention_arbiter #(.ADDR_W(AW)) u_contention_arbiter (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .lft_cs_n(lft_cs_n), .lft_addr(lft_addr), .lft_wr_n(lft_wr_n),
        .lft_busy_in_n(lft_busy_in_n),
        .rgt_cs_n(rgt_cs_n), .rgt_addr(rgt_addr), .rgt_wr_n(rgt_wr_n),
        .rgt_busy_in_n(rgt_busy_in_n),
        .lft_busy_n(lft_busy_n), .rgt_busy_n(rgt_busy_n),
        .lft_wr_en(lft_wr_en), .rgt_wr_en(rgt_wr_en)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag,
                        input bit lc, input int la, input bit lw, input bit lb,
                        input bit rc, input int ra, input bit rw, input bit rb,
                        input bit sm);
        int  own_n;
        bit  hit, lo, ro, inh_l, inh_r;
        @(negedge clk);
        lft_cs_n = lc; lft_addr = AW'(la); lft_wr_n = lw; lft_busy_in_n = lb;
        rgt_cs_n = rc; rgt_addr = AW'(ra); rgt_wr_n = rw; rgt_busy_in_n = rb;
        slave_mode = sm;
        #1;
        hit = !lc && !rc && (la == ra);
        if (sm || !hit) own_n = 0;
        else if (m_own != 0) own_n = m_own;
        else begin
            lo = m_lv && (m_la == la);
            ro = m_rv && (m_ra == ra);
            own_n = (ro && !lo) ? 2 : 1;
        end
        inh_l = sm ? !lb : (own_n == 2);
        inh_r = sm ? !rb : (own_n == 1);
        chk(tag, "lft_busy_n", lft_busy_n, !(m_own == 2));
        chk(tag, "rgt_busy_n", rgt_busy_n, !(m_own == 1));
        chk(tag, "lft_wr_en", lft_wr_en, !lc && !lw && !inh_l);
        chk(tag, "rgt_wr_en", rgt_wr_en, !rc && !rw && !inh_r);
        chk("R4", "both_busy_low", !lft_busy_n && !rgt_busy_n, 1'b0);
        @(posedge clk);
        m_own = own_n;
        m_lv = !lc; m_la = la;
        m_rv = !rc; m_ra = ra;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "lft_busy_n in reset", lft_busy_n, 1'b1);
        chk("R10", "rgt_busy_n in reset", rgt_busy_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        // step args: lcs laddr lwr lbin  rcs raddr rwr rbin  slave
        step("R10", 1, 0, 1, 1, 1, 0, 1, 1, 0);
        // R1: different addresses, both writing
        step("R1", 0, 12'h010, 0, 1, 0, 12'h011, 0, 1, 0);
        step("R1", 0, 12'h010, 0, 1, 0, 12'h011, 0, 1, 0);
        // R1: same address, right not enabled
        step("R1", 0, 12'h055, 0, 1, 1, 12'h055, 0, 1, 0);
        step("R1", 0, 12'h055, 0, 1, 1, 12'h055, 0, 1, 0);
        // R1: differ only in top address bit
        step("R1", 0, 12'h400, 0, 1, 0, 12'h000, 0, 1, 0);
        step("R1", 0, 12'h400, 0, 1, 0, 12'h000, 0, 1, 0);
        // R3 / R7: left first, right arrives and writes
        step("R3", 0, 12'h123, 0, 1, 1, 12'h000, 1, 1, 0);
        step("R3", 0, 12'h123, 0, 1, 0, 12'h123, 0, 1, 0);
        step("R7", 0, 12'h123, 0, 1, 0, 12'h123, 0, 1, 0);
        // R6: winner and loser toggle write controls, grant holds
        step("R6", 0, 12'h123, 1, 1, 0, 12'h123, 0, 1, 0);
        step("R6", 0, 12'h123, 0, 1, 0, 12'h123, 1, 1, 0);
        step("R6", 0, 12'h123, 1, 1, 0, 12'h123, 1, 1, 0);
        // R9: release on address change
        step("R9", 0, 12'h124, 0, 1, 0, 12'h123, 0, 1, 0);
        step("R9", 1, 12'h124, 1, 1, 1, 12'h123, 1, 1, 0);
        // R3: right first, then left
        step("R3", 1, 12'h000, 1, 1, 0, 12'h7ff, 0, 1, 0);
        step("R3", 0, 12'h7ff, 0, 1, 0, 12'h7ff, 0, 1, 0);
        step("R7", 0, 12'h7ff, 0, 1, 0, 12'h7ff, 0, 1, 0);
        // R9: release on enable high
        step("R9", 0, 12'h7ff, 0, 1, 1, 12'h7ff, 0, 1, 0);
        step("R9", 1, 12'h7ff, 1, 1, 1, 12'h7ff, 1, 1, 0);
        // R5: simultaneous arrival, left wins
        step("R5", 0, 12'h2aa, 0, 1, 0, 12'h2aa, 0, 1, 0);
        step("R5", 0, 12'h2aa, 0, 1, 0, 12'h2aa, 0, 1, 0);
        step("R9", 1, 12'h2aa, 1, 1, 1, 12'h2aa, 1, 1, 0);
        // R2: two reads, right first
        step("R2", 1, 12'h000, 1, 1, 0, 12'h333, 1, 1, 0);
        step("R2", 0, 12'h333, 1, 1, 0, 12'h333, 1, 1, 0);
        step("R2", 0, 12'h333, 1, 1, 0, 12'h333, 1, 1, 0);
        step("R9", 1, 12'h333, 1, 1, 1, 12'h333, 1, 1, 0);
        // R8: master ignores busy inputs
        step("R8", 0, 12'h001, 0, 0, 0, 12'h002, 0, 0, 0);
        // R8: slave mode, contention present, inputs gate writes
        step("R8", 0, 12'h050, 0, 1, 0, 12'h050, 0, 0, 1);
        step("R8", 0, 12'h050, 0, 0, 0, 12'h050, 0, 1, 1);
        step("R8", 0, 12'h050, 0, 1, 0, 12'h050, 0, 1, 1);
        step("R8", 0, 12'h050, 0, 0, 0, 12'h050, 0, 0, 1);
        // back to master, both already sitting there: tie rule
        step("R5", 0, 12'h050, 0, 1, 0, 12'h050, 0, 1, 0);
        step("R5", 0, 12'h050, 0, 1, 0, 12'h050, 0, 1, 0);
        // switching to slave releases busy
        step("R8", 0, 12'h050, 0, 1, 0, 12'h050, 0, 1, 1);
        step("R8", 1, 12'h050, 1, 1, 1, 12'h050, 1, 1, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule